// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets a host controller reach a small bank of 8-bit configuration registers over four wires: an active-low select, a serial clock, a data input and a data output. A faster system clock oversamples all three host-driven wires through two-flop synchronizers, so the host's clock domain never enters the design. The host shifts in a frame of sixteen bits. The first seven bits are the register address, the eighth bit gives the direction, and the last eight bits carry the data byte.

When the direction bit is 1, the last eight bits are stored in the addressed register. When it is 0, the block sends the addressed register back on the data output while the host keeps clocking. Register 0 is the main control register, and its bit 0 is an active-low bank reset. Register 1 is a strobe register whose bits clear themselves. The stored contents drive the rest of the chip through a flat output bus.

Top module: `cfg_serial_slave`

## Requirements
- R1: Every frame is shifted most significant bit first and sampled on rising serial clock edges, in this order: address bits 6..0, then the direction bit, then data bits 7..0.
- R2: A direction bit of 1 stores the data byte into the addressed register once the sixteenth rising edge has been seen.
- R3: A direction bit of 0 selects a read. The register's bit 7 appears on `ser_dout` after the falling edge that follows the direction bit, and each later falling edge presents the next lower bit, so the host samples every bit on a rising edge.
- R4: `ser_dout` is driven low whenever select is high, during the address and direction bits, throughout write frames, and after the last read bit.
- R5: Raising select before the sixteenth rising edge abandons the frame. Nothing is written, and the next frame starts again at address bit 6.
- R6: After `rst`, register 0 holds 0x81, register 1 holds 0x00, and every register n from 2 upward holds {n[3:0], ~n[3:0]}.
- R7: Writing register 0 with bit 0 cleared returns every register, register 0 included, to its R6 value. Writing register 0 with bit 0 set stores the byte as written.
- R8: Writing register 1 places the byte on `cfg_strobe_o` for exactly one system clock, after which the output returns to zero. Register 1 always reads back as 0x00.
- R9: Any address at or above NUM_REGS is ignored on a write and reads back as 0x00.
- R10: Rising serial clock edges after the sixteenth, while select stays low, cause no further write and leave `ser_dout` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| ser_csn | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial clock from the host, idle low |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data toward the host |
| cfg_regs_o | output | NUM_REGS*8 | Register contents, register n in bits [8n+7:8n] (register 1 slot shows the strobe) |
| cfg_strobe_o | output | 8 | Self-clearing strobe bits, high for one system clock |

## Verification
The hardest situation to reach is a frame that is cut off part-way through. In that case the receive counter holds a partial address and data bits while the bank must remain untouched. The bench drives exactly ten serial bits of a write and then releases select. It confirms that the target register still holds its old value, and then that a complete frame immediately afterwards lands correctly. A second awkward case is a run of surplus clock pulses after a full frame. The bench sends three extra rising edges with data held high and checks that the register keeps the written byte and that the output stays low.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t MAIN_ADDR     = addr_t'(0);
    localparam addr_t STROBE_ADDR   = addr_t'(1);
    localparam int    MAIN_NRST_BIT = 0;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    function automatic byte_t reg_default(input addr_t n);
        logic [3:0] low;
        low = n[3:0];
        if (n == MAIN_ADDR)   return 8'h81;
        if (n == STROBE_ADDR) return 8'h00;
        return {low, ~low};
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                stab_q <= meta_q;
            end
        end
        assign q_o[b] = stab_q;
    end
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    csn_s,
    input  logic    sclk_s,
    input  logic    din_s,
    input  byte_t   rd_data,
    output addr_t   rd_addr,
    output wr_req_t wr_o,
    output logic    dout_o
);
    localparam int              CNT_W    = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_DIR  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(FRAME_BITS);

    logic              sclk_q;
    logic [CNT_W-1:0]  cnt_q;
    addr_t             addr_q;
    logic [DATA_W-2:0] data_q;
    byte_t             shift_q;
    logic              rd_phase_q;
    logic              dout_q;
    wr_req_t           wr_q;
    logic              rise_w, fall_w;

    assign rise_w  = sclk_s & ~sclk_q;
    assign fall_w  = ~sclk_s & sclk_q;
    assign rd_addr = addr_q;
    assign wr_o    = wr_q;
    assign dout_o  = dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b0;
            cnt_q      <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            shift_q    <= '0;
            rd_phase_q <= 1'b0;
            dout_q     <= 1'b0;
            wr_q       <= '0;
        end else begin
            sclk_q  <= sclk_s;
            wr_q.en <= 1'b0;
            if (csn_s) begin
                cnt_q      <= '0;
                rd_phase_q <= 1'b0;
                dout_q     <= 1'b0;
            end else begin
                if (rise_w && cnt_q < CNT_DONE) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q < CNT_DIR) begin
                        addr_q <= {addr_q[ADDR_W-2:0], din_s};
                    end else if (cnt_q == CNT_DIR) begin
                        rd_phase_q <= ~din_s;
                        shift_q    <= rd_data;
                    end else begin
                        data_q <= {data_q[DATA_W-3:0], din_s};
                        if (cnt_q == CNT_LAST && !rd_phase_q) begin
                            wr_q <= '{en: 1'b1, addr: addr_q, data: {data_q, din_s}};
                        end
                    end
                end
                if (fall_w) begin
                    if (rd_phase_q && cnt_q < CNT_DONE) begin
                        dout_q  <= shift_q[DATA_W-1];
                        shift_q <= {shift_q[DATA_W-2:0], 1'b0};
                    end else begin
                        dout_q <= 1'b0;
                    end
                end
            end
        end
    end

    AST_IDLE_DOUT_LOW: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> !dout_o); // R4
    AST_WRITE_AFTER_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |-> cnt_q == CNT_DONE); // R2
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_DONE); // R10
    AST_DOUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_q) |-> $past(fall_w || csn_s)); // R3
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr_i,
    input  addr_t                 rd_addr,
    output byte_t                 rd_data,
    output logic [NUM_REGS*8-1:0] regs_o,
    output byte_t                 strobe_o
);
    localparam int    IDX_W   = $clog2(NUM_REGS);
    localparam addr_t LIMIT_A = addr_t'(NUM_REGS);

    byte_t view[NUM_REGS];
    logic  main_clr;

    assign main_clr = wr_i.en && wr_i.addr == MAIN_ADDR && !wr_i.data[MAIN_NRST_BIT];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam addr_t MY_ADDR = addr_t'(i);
        logic hit;
        assign hit = wr_i.en && wr_i.addr == MY_ADDR;
        if (MY_ADDR == STROBE_ADDR) begin : g_strobe
            byte_t strobe_q;
            always_ff @(posedge clk) begin
                if (rst || main_clr) strobe_q <= '0;
                else if (hit)        strobe_q <= wr_i.data;
                else                 strobe_q <= '0;
            end
            assign view[i]  = strobe_q;
            assign strobe_o = strobe_q;
        end else begin : g_store
            byte_t val_q;
            always_ff @(posedge clk) begin
                if (rst || main_clr) val_q <= reg_default(MY_ADDR);
                else if (hit)        val_q <= wr_i.data;
            end
            assign view[i] = val_q;
        end
        assign regs_o[i*8 +: 8] = view[i];
    end

    always_comb begin
        if (rd_addr < LIMIT_A && rd_addr != STROBE_ADDR) rd_data = view[rd_addr[IDX_W-1:0]];
        else                                            rd_data = '0;
    end

    AST_STROBE_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != 0 && !wr_i.en) |=> strobe_o == 0); // R8
    AST_MAIN_CLEAR_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        main_clr |=> view[0] == reg_default(MAIN_ADDR)); // R7
    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && wr_i.addr >= LIMIT_A) |=> $stable(regs_o)); // R9
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ser_csn,
    input  logic                  ser_clk,
    input  logic                  ser_din,
    output logic                  ser_dout,
    output logic [NUM_REGS*8-1:0] cfg_regs_o,
    output logic [7:0]            cfg_strobe_o
);
    logic [2:0] raw_w, sync_w;
    wr_req_t    wr_w;
    addr_t      rd_addr_w;
    byte_t      rd_data_w;

    assign raw_w = {ser_csn, ser_clk, ser_din};

    cfg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d_i(raw_w), .q_o(sync_w)
    );

    cfg_frame_rx u_rx (
        .clk(clk), .rst(rst),
        .csn_s(sync_w[2]), .sclk_s(sync_w[1]), .din_s(sync_w[0]),
        .rd_data(rd_data_w), .rd_addr(rd_addr_w), .wr_o(wr_w), .dout_o(ser_dout)
    );

    cfg_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .wr_i(wr_w), .rd_addr(rd_addr_w),
        .rd_data(rd_data_w), .regs_o(cfg_regs_o), .strobe_o(cfg_strobe_o)
    );
endmodule

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb_top;
    localparam int NR   = 16;
    localparam int HALF = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic csn = 1'b1, sclk = 1'b0, din = 1'b0;
    logic dout;
    logic [NR*8-1:0] regs;
    logic [7:0] strobe;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model[NR];
    logic [7:0] exp_q[$];
    int strobe_hits = 0;
    logic [7:0] strobe_last = '0;

    always #10 clk = ~clk;

    cfg_serial_slave #(.NUM_REGS(NR)) dut_i (
        .clk(clk), .rst(rst), .ser_csn(csn), .ser_clk(sclk), .ser_din(din),
        .ser_dout(dout), .cfg_regs_o(regs), .cfg_strobe_o(strobe)
    );

    function automatic logic [7:0] dflt(input int n);
        logic [3:0] l;
        l = n[3:0];
        if (n == 0) return 8'h81;
        if (n == 1) return 8'h00;
        return {l, ~l};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int i = 0; i < NR; i++) model[i] = dflt(i);
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NR; i++)
            chk(regs[i*8 +: 8] == model[i], tag, regs[i*8 +: 8], model[i]);
    endtask

    task automatic frame(input logic [6:0] a, input logic dir, input logic [7:0] d,
                         input int nbits, input int extra);
        logic [15:0] bits;
        bits = {a, dir, d};
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 15; k > 15 - nbits; k--) begin
            din = bits[k];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        for (int k = 0; k < extra; k++) begin
            din = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        din = 1'b0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        frame(a, 1'b1, d, 16, 0);
        if (a < NR) begin
            if (a == 0 && !d[0]) reset_model();
            else if (a != 1)     model[a] = d;
        end
    endtask

    task automatic rd(input logic [6:0] a);
        exp_q.push_back((a < NR && a != 1) ? model[a] : 8'h00);
        frame(a, 1'b0, 8'h00, 16, 0);
    endtask

    // Monitor: samples dout at every host rising edge
    int mcnt = 0;
    logic mdir = 1'b0;
    logic [7:0] mbyte = '0;
    always @(posedge sclk or posedge csn) begin
        if (csn) begin
            mcnt = 0;
        end else begin
            if (mcnt == 7) mdir = din;
            if (mcnt >= 8 && mcnt < 16 && !mdir) begin
                mbyte = {mbyte[6:0], dout};
                if (mcnt == 15) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected read", mbyte, 8'h00);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(mbyte == e, "R3/R9 read data", mbyte, e);
                    end
                end
            end else begin
                chk(dout == 1'b0, "R4/R10 dout low outside read data", {7'b0, dout}, 8'h00);
            end
            mcnt++;
        end
    end

    always @(negedge clk) begin
        if (strobe != 0) begin
            strobe_hits++;
            strobe_last = strobe;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        reset_model();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_bank("R6 reset values");
        chk(dout == 1'b0, "R4 idle dout", {7'b0, dout}, 8'h00);

        wr(7'd5, 8'hA5);
        chk(regs[5*8 +: 8] == 8'hA5, "R2 write reg5", regs[5*8 +: 8], 8'hA5);
        rd(7'd5);
        rd(7'd9);
        wr(7'd12, 8'h3E);
        rd(7'd12);

        wr(7'd0, 8'hC3);
        chk(regs[7:0] == 8'hC3, "R7 main write with bit0 set", regs[7:0], 8'hC3);
        rd(7'd0);
        wr(7'd3, 8'h5A);
        wr(7'd0, 8'h00);
        check_bank("R7 bank back to defaults");

        strobe_hits = 0;
        wr(7'd1, 8'hA6);
        chk(strobe_hits == 1, "R8 strobe one cycle", 8'(strobe_hits), 8'd1);
        chk(strobe_last == 8'hA6, "R8 strobe value", strobe_last, 8'hA6);
        chk(strobe == 8'h00, "R8 strobe cleared", strobe, 8'h00);
        rd(7'd1);

        wr(7'd100, 8'hFF);
        check_bank("R9 out-of-range write ignored");
        rd(7'd100);

        frame(7'd4, 1'b1, 8'hF0, 10, 0);
        chk(regs[4*8 +: 8] == model[4], "R5 aborted frame no write", regs[4*8 +: 8], model[4]);
        wr(7'd4, 8'h3C);
        chk(regs[4*8 +: 8] == 8'h3C, "R5 next frame after abort", regs[4*8 +: 8], 8'h3C);

        frame(7'd6, 1'b1, 8'h99, 16, 3);
        model[6] = 8'h99;
        chk(regs[6*8 +: 8] == 8'h99, "R10 extra clocks ignored", regs[6*8 +: 8], 8'h99);
        rd(7'd6);
        check_bank("R1 final bank");
        chk(exp_q.size() == 0, "R3 all reads observed", 8'(exp_q.size()), 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule